// File: doc/BRIEF.md
# Two-wire Wiper Register Controller

This block is a two-wire bus target that owns an 8-bit wiper setting, a shadow copy of that setting that models nonvolatile storage, and a software lock flag. A bus master changes them with a three-byte write: the target address, a command byte whose upper three bits select the operation, and a payload byte. A read returns the live wiper value. The clock and data lines arrive as plain inputs, and the data line is pulled low through an output-enable, in the usual open-drain fashion. Two strap inputs pick one of four bus addresses.

Bus lines are resynchronised into the core clock, and start and stop conditions are recovered from them. Commands copy the payload to the wiper or the shadow, copy one into the other, or set the lock. A copy from the wiper to the shadow holds a busy flag for a fixed, parameterised number of core cycles before the shadow changes.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: The target answers only the 7-bit address picked by `strap_i` (bit 1 is the high strap, bit 0 the low one): 00 selects 0x18, 10 selects 0x1A, 01 selects 0x4C, 11 selects 0x4E. It acknowledges by pulling SDA low during the ninth clock of each accepted byte.
- R2: For any other address the target acknowledges nothing, keeps SDA released for the rest of the transfer and changes no state.
- R3: Command bits 7..5 = 000 copy the payload byte to the wiper, and `wiper_o` shows it once the payload byte has been acknowledged.
- R4: Command 001 writes the payload to the shadow register and leaves `wiper_o` unchanged.
- R5: Command 110 raises `busy_o` for exactly STORE_CYC core cycles and then copies the wiper into the shadow.
- R6: Command 101 copies the shadow into the wiper.
- R7: Command 010 sets the lock flag from payload bit 0. While the lock is set, commands 000, 001, 101 and 110 are acknowledged but change nothing. Command 010 still works, so it can clear the lock.
- R8: Commands 100, 011 and 111 change nothing, and command bits 4..0 have no effect on any command.
- R9: A stop or a repeated start before the payload byte completes drops the transfer, and no partial byte is applied.
- R10: A read (R/W bit = 1) sends the wiper value MSB first, and a master not-acknowledge ends it.
- R11: After reset the lock is clear, `busy_o` is low, SDA is released, and both the wiper and the shadow hold NV_INIT (default 0x80).
- R12: The target starts pulling SDA low only while the synchronised SCL is low, and `sda_oe_o` is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Address strap pins |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| wiper_o | output | 8 | Current wiper value |
| busy_o | output | 1 | Shadow copy in progress |

## Verification
The assertions assume a bus whose SCL phases each last several core cycles, so that every edge passes the synchronisers before the next one arrives. They also assume a master that changes SDA only while SCL is low, except when it forms a start or a stop. The bench drives each quarter bit period for five core cycles, moves SDA only after SCL has fallen, and models the wired-AND line as its own drive ANDed with the inverse of `sda_oe_o`. It sweeps every strap and address pairing, a range of wiper values with varied low command bits, and each opcode with the lock both clear and set.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    OP_WIPER   = 3'b000,
    OP_SHADOW  = 3'b001,
    OP_LOCK    = 3'b010,
    OP_RSV3    = 3'b011,
    OP_NOP     = 3'b100,
    OP_RESTORE = 3'b101,
    OP_STORE   = 3'b110,
    OP_RSV7    = 3'b111
  } op_e;

  // strap {hi, lo} -> 7-bit bus address
  function automatic logic [6:0] strap_addr(logic [1:0] s);
    case (s)
      2'b00:   return 7'h18;
      2'b10:   return 7'h1A;
      2'b01:   return 7'h4C;
      default: return 7'h4E;
    endcase
  endfunction
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_prev   = scl_q[STAGES];
  assign sda_prev   = sda_q[STAGES];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       cmd_vld_o,
  output logic [2:0] cmd_op_o,
  output logic [7:0] cmd_data_o
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_TXLD, S_IGN} st_e;

  st_e        state_q;
  logic [3:0] bit_cnt_q;
  logic [1:0] byte_idx_q;
  logic [7:0] shreg_q;
  logic [6:0] txreg_q;
  logic [2:0] op_q;
  logic       rw_q, oe_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      txreg_q    <= '0;
      op_q       <= '0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start_i) begin
        state_q    <= S_RX;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        oe_q       <= 1'b0;
      end else if (stop_i) begin
        state_q <= S_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          S_RX: begin
            if (scl_rise_i) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              state_q   <= S_ACK;
              oe_q      <= 1'b1;
              unique case (byte_idx_q)
                2'd0: begin
                  if (shreg_q[7:1] == dev_addr_i) rw_q <= shreg_q[0];
                  else begin
                    state_q <= S_IGN;
                    oe_q    <= 1'b0;
                  end
                end
                2'd1: op_q <= shreg_q[7:5];  // low command bits dropped
                2'd2: vld_q <= 1'b1;
                default: begin
                  state_q <= S_IGN;
                  oe_q    <= 1'b0;
                end
              endcase
            end
          end
          S_ACK: if (scl_fall_i) begin
            if (rw_q) begin
              txreg_q   <= rd_data_i[6:0];
              oe_q      <= ~rd_data_i[7];
              bit_cnt_q <= 4'd1;
              state_q   <= S_TX;
            end else begin
              oe_q       <= 1'b0;
              byte_idx_q <= byte_idx_q + 2'd1;
              state_q    <= S_RX;
            end
          end
          S_TX: if (scl_fall_i) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= S_MACK;
            end else begin
              oe_q      <= ~txreg_q[6];
              txreg_q   <= {txreg_q[5:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          S_MACK: if (scl_rise_i) state_q <= sda_i ? S_IGN : S_TXLD;
          S_TXLD: if (scl_fall_i) begin
            txreg_q   <= rd_data_i[6:0];
            oe_q      <= ~rd_data_i[7];
            bit_cnt_q <= 4'd1;
            state_q   <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign cmd_vld_o  = vld_q;
  assign cmd_op_o   = op_q;
  assign cmd_data_o = shreg_q;

  assert_oe_rise_scl_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_i);
  assert_ignore_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IGN) |-> !oe_q);
  assert_cmd_after_rx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (state_q == S_ACK) && !rw_q);
endmodule

// File: rtl/wiper_store.sv
module wiper_store
  import wiper_pkg::*;
#(
  parameter int         WIDTH     = 8,
  parameter int         STORE_CYC = 100,
  parameter logic [7:0] NV_INIT   = 8'h80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [WIDTH-1:0] cmd_data_i,
  output logic [WIDTH-1:0] wiper_o,
  output logic             busy_o
);
  localparam int CW = $clog2(STORE_CYC + 1);

  logic [WIDTH-1:0] wiper_q, shadow_q;
  logic             lock_q;
  logic [CW-1:0]    busy_cnt_q;
  logic             busy;

  assign busy = (busy_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_q    <= WIDTH'(NV_INIT);
      shadow_q   <= WIDTH'(NV_INIT);
      lock_q     <= 1'b0;
      busy_cnt_q <= '0;
    end else begin
      if (busy) begin
        busy_cnt_q <= busy_cnt_q - CW'(1);
        if (busy_cnt_q == CW'(1)) shadow_q <= wiper_q;
      end
      if (cmd_vld_i) begin
        case (op_e'(cmd_op_i))
          OP_LOCK:    lock_q <= cmd_data_i[0];
          OP_WIPER:   if (!lock_q) wiper_q <= cmd_data_i;
          OP_SHADOW:  if (!lock_q && !busy) shadow_q <= cmd_data_i;
          OP_RESTORE: if (!lock_q) wiper_q <= shadow_q;
          OP_STORE:   if (!lock_q && !busy) busy_cnt_q <= CW'(STORE_CYC);
          default: ;
        endcase
      end
    end
  end

  assign wiper_o = wiper_q;
  assign busy_o  = busy;

  assert_lock_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_q) |-> $stable(wiper_q));
  assert_shadow_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cnt_q > CW'(1)) |=> $stable(shadow_q));
  assert_nop_wiper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i && (cmd_op_i == 3'b100 || cmd_op_i == 3'b011 || cmd_op_i == 3'b111)
    |=> $stable(wiper_q));
  assert_lock_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_q) |-> $past(cmd_vld_i) && $past(cmd_op_i) == 3'b010);
endmodule

// File: rtl/i2c_wiper_ctrl.sv
module i2c_wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int         STORE_CYC = 100,
  parameter logic [7:0] NV_INIT   = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o,
  output logic [7:0] wiper_o,
  output logic       busy_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic       cmd_vld;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;

  i2c_pin_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_cmd_slave i_slave (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .dev_addr_i(strap_addr(strap_i)), .rd_data_i(wiper_o),
    .sda_oe_o, .cmd_vld_o(cmd_vld), .cmd_op_o(cmd_op), .cmd_data_o(cmd_data)
  );

  wiper_store #(.WIDTH(8), .STORE_CYC(STORE_CYC), .NV_INIT(NV_INIT)) i_store (
    .clk_i, .rst_ni, .cmd_vld_i(cmd_vld), .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
    .wiper_o, .busy_o
  );
endmodule

// File: tb/test_i2c_wiper_ctrl.sv
module test_i2c_wiper_ctrl;
  localparam int Q = 5;
  localparam int STORE_CYC = 100;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, mon_clr = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sda_oe, busy;
  logic [7:0] wiper;
  logic sda_line;
  int n_chk = 0, n_bad = 0, busy_hi = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  i2c_wiper_ctrl #(.STORE_CYC(STORE_CYC), .NV_INIT(8'h80)) i_i2c_wiper_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .sda_oe_o(sda_oe), .wiper_o(wiper), .busy_o(busy)
  );

  always @(posedge clk) if (mon_clr) busy_hi <= 0; else if (busy) busy_hi <= busy_hi + 1;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [6:0] addr_of(logic [1:0] s);
    return (s[0] ? 7'h4C : 7'h18) | {5'd0, s[1], 1'b0};
  endfunction

  task automatic wq(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q); sda_m = 1'b0; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q); sda_m = 1'b1; wq(2*Q);
  endtask
  task automatic put_bit(logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask
  task automatic get_ack(output logic ack);
    logic oe_a;
    sda_m = 1'b1; wq(Q); oe_a = sda_oe; scl_m = 1'b1; wq(Q);
    ack = !sda_line; wq(Q);
    chk("R12 sda_oe stable over SCL high", sda_oe, oe_a);
    scl_m = 1'b0; wq(Q);
  endtask
  task automatic put_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(ack);
  endtask
  task automatic get_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    end
    put_bit(nack);
  endtask
  task automatic write3(logic [6:0] a, logic [7:0] ins, logic [7:0] d, output logic [2:0] acks);
    bus_start;
    put_byte({a, 1'b0}, acks[2]);
    put_byte(ins, acks[1]);
    put_byte(d, acks[0]);
    bus_stop; wq(4);
  endtask
  task automatic read1(logic [6:0] a, output logic ack, output logic [7:0] d);
    bus_start;
    put_byte({a, 1'b1}, ack);
    get_byte(d, 1'b1);
    bus_stop; wq(4);
  endtask

  initial begin
    logic [2:0] acks;
    logic ack;
    logic [7:0] rd, prev, v;
    logic [6:0] dev;
    wq(5);
    rst_n = 1'b1; wq(5);
    chk("R11 wiper reset", wiper, 8'h80);
    chk("R11 busy reset", busy, 0);
    chk("R11 sda released", sda_oe, 0);

    // R1/R2 strap x address sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int t = 0; t < 4; t++) begin
        prev = wiper;
        v = 8'(16*s + t + 1);
        write3(addr_of(2'(t)), 8'h00, v, acks);
        if (s == t) begin
          chk("R1 acks on match", acks, 3'b111);
          chk("R3 wiper after match", wiper, v);
        end else begin
          chk("R2 acks on mismatch", acks, 3'b000);
          chk("R2 wiper unchanged", wiper, prev);
        end
      end
    end
    dev = addr_of(strap);

    // R3/R8/R10 value sweep with varied low command bits
    for (int i = 0; i < 18; i++) begin
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 37) & 255);
      write3(dev, {3'b000, 5'(i * 7)}, v, acks);
      chk("R3/R8 wiper write", wiper, v);
      read1(dev, ack, rd);
      chk("R10 read ack", ack, 1);
      chk("R10 read data", rd, v);
    end

    // R4, R6
    write3(dev, 8'h00, 8'hC3, acks);
    write3(dev, 8'h3F, 8'h3C, acks);
    chk("R4 wiper untouched by shadow write", wiper, 8'hC3);
    write3(dev, 8'hA0, 8'h00, acks);
    chk("R6 restore", wiper, 8'h3C);

    // R5 store with exact busy length
    write3(dev, 8'h00, 8'hA5, acks);
    mon_clr = 1'b0;
    write3(dev, 8'hC0, 8'h00, acks);
    chk("R5 busy during store", busy, 1);
    wq(2*STORE_CYC);
    chk("R5 busy dropped", busy, 0);
    chk("R5 busy length", busy_hi, STORE_CYC);
    mon_clr = 1'b1;
    write3(dev, 8'h00, 8'h00, acks);
    write3(dev, 8'hA0, 8'h00, acks);
    chk("R5 stored value restored", wiper, 8'hA5);

    // R8 no-op opcodes
    write3(dev, 8'h80, 8'h77, acks);
    chk("R8 op100 ack", acks, 3'b111);
    chk("R8 op100 wiper", wiper, 8'hA5);
    write3(dev, 8'h60, 8'h77, acks);
    chk("R8 op011 wiper", wiper, 8'hA5);
    write3(dev, 8'hE0, 8'h77, acks);
    chk("R8 op111 wiper", wiper, 8'hA5);
    write3(dev, 8'h00, 8'h01, acks);
    write3(dev, 8'hA0, 8'h00, acks);
    chk("R8 shadow untouched by no-ops", wiper, 8'hA5);

    // R7 lock
    write3(dev, 8'h00, 8'h5A, acks);
    write3(dev, 8'h40, 8'h01, acks);
    write3(dev, 8'h00, 8'h22, acks);
    chk("R7 locked write acked", acks, 3'b111);
    chk("R7 locked wiper write", wiper, 8'h5A);
    write3(dev, 8'hA0, 8'h00, acks);
    chk("R7 locked restore", wiper, 8'h5A);
    write3(dev, 8'hC0, 8'h00, acks);
    chk("R7 locked store no busy", busy, 0);
    write3(dev, 8'h20, 8'h22, acks);
    write3(dev, 8'h40, 8'h00, acks);
    write3(dev, 8'hA0, 8'h00, acks);
    chk("R7 unlocked, shadow kept", wiper, 8'hA5);

    // R9 abandoned transfers
    bus_start; put_byte({dev, 1'b0}, ack); put_byte(8'h00, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop; wq(4);
    chk("R9 stop mid-byte", wiper, 8'hA5);
    bus_start; put_byte({dev, 1'b0}, ack); put_byte(8'h00, ack);
    bus_stop; wq(4);
    chk("R9 stop before payload", wiper, 8'hA5);
    bus_start; put_byte({dev, 1'b0}, ack); put_byte(8'h00, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_start; put_byte({dev, 1'b0}, acks[2]); put_byte(8'h00, acks[1]); put_byte(8'h66, acks[0]);
    bus_stop; wq(4);
    chk("R9 repeated start acks", acks, 3'b111);
    chk("R9 repeated start wiper", wiper, 8'h66);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule